// File: doc/BRIEF.md
# Pipelined Interpolating Sine-Cosine Generator

This block produces a signed sine and cosine pair for an angle given as a binary fraction of one full turn. It is meant to feed twiddle factors to a streaming transform datapath. It accepts one new angle on every clock and returns the matching pair a fixed number of cycles later. The surrounding timing control accounts for that latency, so the block has no handshake.

Storage is limited to one eighth of a circle. The three top angle bits select an octant. Odd octants mirror the remaining angle about 45 degrees, and the octant then decides whether sine and cosine swap and which of them change sign. The next five bits index a 33-point coarse table that spans 0 to 45 degrees. Each table point carries its value and a slope to the next point. The low angle bits scale that slope in a small multiply that refines the coarse value. The table contents are computed at elaboration from an integer series expansion, so no table is written out by hand.

Top module: `sincos_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `out_valid` is 0.
- R2: `out_valid` equals the `in_valid` value sampled four rising edges earlier. An input sampled at edge p appears on the outputs after edge p+3. The latency does not depend on the angle or on the input pattern.
- R3: For every angle code a (12 bits by default), `out_sin` and `out_cos` each differ by at most 2 LSB from 4095·sin(2πa/4096) and 4095·cos(2πa/4096).
- R4: Both outputs stay within −4095..+4095, which is the amplitude 2^(OUT_W−1)−1.
- R5: The quarter-turn codes give exact results. Code 0 gives (sin, cos) = (0, 4095). Code 1024 gives (4095, 0). Code 2048 gives (0, −4095). Code 3072 gives (−4095, 0).
- R6: Odd symmetry is exact. For every code a from 1 to 4095, the sine at code 4096−a is the exact negation of the sine at a, and the two cosines are equal.
- R7: The odd 45-degree codes (512, 1536, 2560, 3584) give |sin| = |cos| = 2896.
- R8: One angle is accepted per clock. Back-to-back valid inputs give back-to-back valid outputs in input order, and no cycle is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Angle on `in_angle` is to be converted |
| in_angle | input | ANGLE_W | Angle as an unsigned fraction of a full turn |
| out_valid | output | 1 | Output pair is valid |
| out_sin | output | OUT_W | Signed sine, full scale 2^(OUT_W−1)−1 |
| out_cos | output | OUT_W | Signed cosine, full scale 2^(OUT_W−1)−1 |

## Verification
The assertions assume that reset is applied on the first edges before anything is checked, and that only the reset clears the pipeline, so an input sampled after reset has fallen always reaches the output.

The latency and cardinal-angle properties look back four edges. For that reason they are gated by a count of edges since reset and never compare against inputs sampled while reset was high. The stimulus drives a defined `in_valid` of 0 throughout reset. It then sweeps every angle code back to back, and finally sends a sparse burst with gaps, so that both dense and idle patterns meet the latency property.

// File: rtl/scgen_pkg.sv
package scgen_pkg;

    // Coarse table: 2**IDX_W segments across one octant, plus one end point
    localparam int IDX_W = 5;
    localparam int TAB_N = 1 << IDX_W;
    localparam int Q     = 30;
    localparam longint PI_Q = 64'sd3373259426;  // pi scaled by 2**30

    typedef struct packed {
        logic swap;   // exchange sine and cosine
        logic neg_s;  // negate the sine
        logic neg_c;  // negate the cosine
    } octctl_t;

    // Maps the octant number to the swap and negate controls
    function automatic octctl_t decode_octant(input logic [2:0] oct);
        octctl_t c;
        c.swap  = oct[0] ^ oct[1];
        c.neg_s = oct[2];
        c.neg_c = oct[1] ^ oct[2];
        return c;
    endfunction

    // Series expansion in Q30 fixed point, for x in [0, pi/4]
    function automatic longint series_q(input longint x, input bit want_cos);
        longint acc;
        longint term;
        term = want_cos ? (64'sd1 <<< Q) : x;
        acc  = term;
        for (int n = 1; n <= 5; n++) begin
            longint k;
            k    = want_cos ? longint'(2 * n) : longint'(2 * n + 1);
            term = -((((term * x) >>> Q) * x) >>> Q) / (k * (k - 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Table point idx (0..TAB_N) scaled to amp, rounded to nearest
    function automatic int table_val(input int idx, input int amp, input bit want_cos);
        longint x;
        longint v;
        x = (PI_Q * longint'(idx)) / longint'(4 * TAB_N);
        v = series_q(x, want_cos);
        return int'((v * longint'(amp) + (64'sd1 <<< (Q - 1))) >>> Q);
    endfunction

endpackage

// File: rtl/scgen_fold.sv
module scgen_fold #(
    parameter int ANGLE_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [ANGLE_W-1:0]        in_angle,
    output logic                      f_valid,
    output scgen_pkg::octctl_t        f_ctl,
    output logic [scgen_pkg::IDX_W:0] f_idx,
    output logic [ANGLE_W-4-scgen_pkg::IDX_W:0] f_frac
);
    localparam int RW     = ANGLE_W - 3;
    localparam int FRAC_W = RW - scgen_pkg::IDX_W;
    localparam logic [RW:0] FULL_OCT = (RW+1)'(1) << RW;

    logic [2:0]    oct;
    logic [RW-1:0] resid;
    logic [RW:0]   mirrored;

    assign oct      = in_angle[ANGLE_W-1 -: 3];
    assign resid    = in_angle[RW-1:0];
    assign mirrored = oct[0] ? (FULL_OCT - {1'b0, resid}) : {1'b0, resid};

    always_ff @(posedge clk) begin
        if (rst) begin
            f_valid <= 1'b0;
            f_ctl   <= '0;
            f_idx   <= '0;
            f_frac  <= '0;
        end else begin
            f_valid <= in_valid;
            f_ctl   <= scgen_pkg::decode_octant(oct);
            f_idx   <= mirrored[RW:FRAC_W];
            f_frac  <= mirrored[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/scgen_rom.sv
module scgen_rom #(
    parameter int OUT_W  = 13,
    parameter int FRAC_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        a_valid,
    input  scgen_pkg::octctl_t          a_ctl,
    input  logic [scgen_pkg::IDX_W:0]   a_idx,
    input  logic [FRAC_W-1:0]           a_frac,
    output logic                        r_valid,
    output scgen_pkg::octctl_t          r_ctl,
    output logic [FRAC_W-1:0]           r_frac,
    output logic signed [OUT_W-1:0]     r_sin_base,
    output logic signed [OUT_W-1:0]     r_sin_slope,
    output logic signed [OUT_W-1:0]     r_cos_base,
    output logic signed [OUT_W-1:0]     r_cos_slope
);
    localparam int AMP = (1 << (OUT_W - 1)) - 1;
    localparam int N   = scgen_pkg::TAB_N;

    logic signed [OUT_W-1:0] sin_base  [0:N];
    logic signed [OUT_W-1:0] sin_slope [0:N];
    logic signed [OUT_W-1:0] cos_base  [0:N];
    logic signed [OUT_W-1:0] cos_slope [0:N];

    for (genvar i = 0; i <= N; i++) begin : g_tab
        localparam int S0 = scgen_pkg::table_val(i, AMP, 1'b0);
        localparam int C0 = scgen_pkg::table_val(i, AMP, 1'b1);
        localparam int S1 = (i < N) ? scgen_pkg::table_val(i + 1, AMP, 1'b0) : S0;
        localparam int C1 = (i < N) ? scgen_pkg::table_val(i + 1, AMP, 1'b1) : C0;
        assign sin_base[i]  = OUT_W'(S0);
        assign cos_base[i]  = OUT_W'(C0);
        assign sin_slope[i] = OUT_W'(S1 - S0);
        assign cos_slope[i] = OUT_W'(C1 - C0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid     <= 1'b0;
            r_ctl       <= '0;
            r_frac      <= '0;
            r_sin_base  <= '0;
            r_sin_slope <= '0;
            r_cos_base  <= '0;
            r_cos_slope <= '0;
        end else begin
            r_valid     <= a_valid;
            r_ctl       <= a_ctl;
            r_frac      <= a_frac;
            r_sin_base  <= sin_base[a_idx];
            r_sin_slope <= sin_slope[a_idx];
            r_cos_base  <= cos_base[a_idx];
            r_cos_slope <= cos_slope[a_idx];
        end
    end
endmodule

// File: rtl/scgen_lerp.sv
module scgen_lerp #(
    parameter int OUT_W  = 13,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OUT_W-1:0] base,
    input  logic signed [OUT_W-1:0] slope,
    input  logic [FRAC_W-1:0]       frac,
    output logic signed [OUT_W-1:0] y
);
    localparam int PW = OUT_W + FRAC_W + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [PW-1:0] frac_s;

    assign frac_s = PW'($signed({1'b0, frac}));
    assign prod   = PW'(slope) * frac_s;
    assign step   = (prod + PW'(1 << (FRAC_W - 1))) >>> FRAC_W;

    always_ff @(posedge clk) begin
        if (rst) y <= '0;
        else     y <= base + OUT_W'(step);
    end
endmodule

// File: rtl/scgen_unfold.sv
module scgen_unfold #(
    parameter int OUT_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    u_valid,
    input  scgen_pkg::octctl_t      u_ctl,
    input  logic signed [OUT_W-1:0] u_s,
    input  logic signed [OUT_W-1:0] u_c,
    output logic                    o_valid,
    output logic signed [OUT_W-1:0] o_sin,
    output logic signed [OUT_W-1:0] o_cos
);
    logic signed [OUT_W-1:0] pick_s;
    logic signed [OUT_W-1:0] pick_c;

    assign pick_s = u_ctl.swap ? u_c : u_s;
    assign pick_c = u_ctl.swap ? u_s : u_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_sin   <= '0;
            o_cos   <= '0;
        end else begin
            o_valid <= u_valid;
            o_sin   <= u_ctl.neg_s ? -pick_s : pick_s;
            o_cos   <= u_ctl.neg_c ? -pick_c : pick_c;
        end
    end
endmodule

// File: rtl/sincos_gen.sv
module sincos_gen #(
    parameter int ANGLE_W = 12,
    parameter int OUT_W   = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [ANGLE_W-1:0]      in_angle,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_sin,
    output logic signed [OUT_W-1:0] out_cos
);
    localparam int FRAC_W = ANGLE_W - 3 - scgen_pkg::IDX_W;

    // Stage 1: octant fold
    logic                      f_valid;
    scgen_pkg::octctl_t        f_ctl;
    logic [scgen_pkg::IDX_W:0] f_idx;
    logic [FRAC_W-1:0]         f_frac;

    scgen_fold #(.ANGLE_W(ANGLE_W)) fold_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
        .f_valid(f_valid), .f_ctl(f_ctl), .f_idx(f_idx), .f_frac(f_frac)
    );

    // Stage 2: coarse value and slope lookup
    logic                    r_valid;
    scgen_pkg::octctl_t      r_ctl;
    logic [FRAC_W-1:0]       r_frac;
    logic signed [OUT_W-1:0] r_sb, r_ss, r_cb, r_cs;

    scgen_rom #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) rom_i (
        .clk(clk), .rst(rst), .a_valid(f_valid), .a_ctl(f_ctl),
        .a_idx(f_idx), .a_frac(f_frac),
        .r_valid(r_valid), .r_ctl(r_ctl), .r_frac(r_frac),
        .r_sin_base(r_sb), .r_sin_slope(r_ss),
        .r_cos_base(r_cb), .r_cos_slope(r_cs)
    );

    // Stage 3: interpolation, one lane per function
    logic signed [OUT_W-1:0] l_s, l_c;
    logic                    l_valid;
    scgen_pkg::octctl_t      l_ctl;

    scgen_lerp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) lerp_sin_i (
        .clk(clk), .rst(rst), .base(r_sb), .slope(r_ss), .frac(r_frac), .y(l_s)
    );
    scgen_lerp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) lerp_cos_i (
        .clk(clk), .rst(rst), .base(r_cb), .slope(r_cs), .frac(r_frac), .y(l_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            l_valid <= 1'b0;
            l_ctl   <= '0;
        end else begin
            l_valid <= r_valid;
            l_ctl   <= r_ctl;
        end
    end

    // Stage 4: swap and sign restore
    scgen_unfold #(.OUT_W(OUT_W)) unfold_i (
        .clk(clk), .rst(rst), .u_valid(l_valid), .u_ctl(l_ctl),
        .u_s(l_s), .u_c(l_c),
        .o_valid(out_valid), .o_sin(out_sin), .o_cos(out_cos)
    );
endmodule

// File: rtl/sincos_gen_chk.sv
module sincos_gen_chk #(
    parameter int ANGLE_W = 12,
    parameter int OUT_W   = 13
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [ANGLE_W-1:0]      in_angle,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_sin,
    input logic signed [OUT_W-1:0] out_cos
);
    localparam int AMP = (1 << (OUT_W - 1)) - 1;
    localparam logic [ANGLE_W-1:0] QUARTER = ANGLE_W'(1) << (ANGLE_W - 2);

    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 4) since_rst <= since_rst + 3'd1;
    end

    longint radius_err;
    assign radius_err = longint'(out_sin) * longint'(out_sin)
                      + longint'(out_cos) * longint'(out_cos)
                      - longint'(AMP) * longint'(AMP);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4) |-> (out_valid == $past(in_valid, 4)));

    assert_near_circle_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (radius_err <= 6 * AMP && radius_err >= -6 * AMP));

    assert_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sin <= AMP && out_sin >= -AMP && out_cos <= AMP && out_cos >= -AMP));

    assert_zero_angle_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4 && $past(in_valid, 4) && $past(in_angle, 4) == '0)
        |-> (out_sin == 0 && out_cos == AMP));

    assert_quarter_angle_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 4 && $past(in_valid, 4) && $past(in_angle, 4) == QUARTER)
        |-> (out_sin == AMP && out_cos == 0));
endmodule

bind sincos_gen sincos_gen_chk #(.ANGLE_W(ANGLE_W), .OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
    .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos)
);

// File: tb/sincos_gen_tb.sv
module sincos_gen_tb_top;
    localparam int AW  = 12;
    localparam int OW  = 13;
    localparam int NA  = 1 << AW;
    localparam int AMP = (1 << (OW - 1)) - 1;
    localparam real TWO_PI = 6.283185307179586;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [AW-1:0]        in_angle = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_sin;
    logic signed [OW-1:0] out_cos;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic          hv [0:3];
    logic [AW-1:0] ha [0:3];
    int res_s [0:NA-1];
    int res_c [0:NA-1];
    bit seen  [0:NA-1];

    always #10 clk = ~clk;

    sincos_gen #(.ANGLE_W(AW), .OUT_W(OW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
        .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos)
    );

    function automatic real absr(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    task automatic expect_int(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // one clock: check what leaves the pipe, then drive the next input
    task automatic step(input logic v, input logic [AW-1:0] a);
        @(negedge clk);
        expect_int("R2", "out_valid vs delayed in_valid", int'(out_valid), int'(hv[3]));
        if (hv[3] && out_valid) begin
            real es, ec;
            es = real'(AMP) * $sin(TWO_PI * real'(ha[3]) / real'(NA));
            ec = real'(AMP) * $cos(TWO_PI * real'(ha[3]) / real'(NA));
            res_s[ha[3]] = int'(out_sin);
            res_c[ha[3]] = int'(out_cos);
            seen[ha[3]]  = 1'b1;
            checks++;
            if (absr(real'(out_sin) - es) > 2.0 || absr(real'(out_cos) - ec) > 2.0) begin
                failures++;
                $display("FAIL R3 angle=%0d actual=(%0d,%0d) expected=(%f,%f)",
                         ha[3], out_sin, out_cos, es, ec);
            end
            checks++;
            if (out_sin > AMP || out_sin < -AMP || out_cos > AMP || out_cos < -AMP) begin
                failures++;
                $display("FAIL R4 angle=%0d actual=(%0d,%0d) expected=|v|<=%0d",
                         ha[3], out_sin, out_cos, AMP);
            end
        end
        hv[3] = hv[2]; ha[3] = ha[2];
        hv[2] = hv[1]; ha[2] = ha[1];
        hv[1] = hv[0]; ha[1] = ha[0];
        hv[0] = v;     ha[0] = a;
        in_valid = v;
        in_angle = a;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; ha[i] = '0; end
        for (int i = 0; i < NA; i++) begin seen[i] = 1'b0; res_s[i] = 0; res_c[i] = 0; end

        // R1: idle during and right after reset
        repeat (3) @(negedge clk);
        expect_int("R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_int("R1", "out_valid after reset", int'(out_valid), 0);

        // R3/R8: every code back to back, one per clock
        for (int a = 0; a < NA; a++) step(1'b1, AW'(a));
        for (int i = 0; i < 6; i++) step(1'b0, '0);

        checks++;
        begin
            int missing;
            missing = 0;
            for (int a = 0; a < NA; a++) if (!seen[a]) missing++;
            if (missing != 0) begin
                failures++;
                $display("FAIL R8 codes returned actual_missing=%0d expected=0", missing);
            end
        end

        // R2: sparse pattern with gaps of varying length
        for (int k = 0; k < 60; k++) begin
            step(1'b1, AW'(k * 97 + 5));
            for (int g = 0; g < (k % 4); g++) step(1'b0, AW'(k));
        end
        for (int i = 0; i < 6; i++) step(1'b0, '0);

        // R5: quarter-turn codes exact
        expect_int("R5", "sin@0",    res_s[0],          0);
        expect_int("R5", "cos@0",    res_c[0],          AMP);
        expect_int("R5", "sin@1024", res_s[NA/4],       AMP);
        expect_int("R5", "cos@1024", res_c[NA/4],       0);
        expect_int("R5", "sin@2048", res_s[NA/2],       0);
        expect_int("R5", "cos@2048", res_c[NA/2],       -AMP);
        expect_int("R5", "sin@3072", res_s[3*NA/4],     -AMP);
        expect_int("R5", "cos@3072", res_c[3*NA/4],     0);

        // R6: exact odd symmetry
        for (int a = 1; a < NA; a++) begin
            expect_int("R6", $sformatf("sin(-a) a=%0d", a), res_s[NA-a], -res_s[a]);
            expect_int("R6", $sformatf("cos(-a) a=%0d", a), res_c[NA-a], res_c[a]);
        end

        // R7: odd 45-degree codes
        for (int k = 1; k < 8; k += 2) begin
            int a;
            a = k * NA / 8;
            expect_int("R7", $sformatf("|sin|@%0d", a), (res_s[a] < 0) ? -res_s[a] : res_s[a], 2896);
            expect_int("R7", $sformatf("|cos|@%0d", a), (res_c[a] < 0) ? -res_c[a] : res_c[a], 2896);
        end

        summary();
    end
endmodule